// File: doc/BRIEF.md
# Core Reset Sequencer with Cause Detection

This block produces the reset that holds a small microcontroller core, and it works out which of four causes started each reset: the power-up event, a low level on the shared board reset pin, a watchdog timeout, or a clock-failure alarm. After power-up it keeps the core in reset while it counts a fixed number of cycles in which the oscillator reports itself running. This gives the clock time to settle before the core starts.

When the watchdog or the clock monitor fires, the block pulls the shared open-drain reset pin low for a fixed number of E-clock cycles and then releases it. A short time later it reads the pin back through a synchroniser. If the pin is high again, the reset came from inside and the core starts at the watchdog or clock-monitor vector. If the pin is still low, something outside is holding it down. The reset is then treated as external: the power-on/external vector is selected and the core stays in reset until the pin is clearly high.

The block runs on the E-clock. The power-up pulse is its only asynchronous reset.

Top module: `rst_seq_ctl`

## Requirements
- R1: While `pwr_up` is high, `core_rst` is 1, `vec_sel` is 00 and `rst_pin_oe_low` is 0.
- R2: After `pwr_up` falls, `core_rst` stays 1 until `osc_ok` has been sampled high on STAB_CYCLES clock edges. It falls at exactly that edge if the pin is high, and it never falls while `osc_ok` stays low.
- R3: If the synchronised pin is low when the stabilisation count ends, `core_rst` stays 1 until the synchronised pin has been high on two consecutive edges.
- R4: Once the core is running, a low level on `osc_ok` has no effect on `core_rst`. Only the power-up pulse restarts the power-on sequence.
- R5: An internal request that is accepted raises `rst_pin_oe_low` on the next edge. The output stays high for exactly DRIVE_CYCLES cycles, and `core_rst` is 1 during the whole sequence.
- R6: After the pin is released, its raw level at the SAMPLE_DELAY-th edge decides the cause. If that level is high, `core_rst` falls SAMPLE_DELAY+2 edges after the release edge, with the vector of the internal source.
- R7: A pin that is still low at that sampling edge (slow rise or outside hold) is classified as external. `vec_sel` becomes 00, and `core_rst` stays 1 until the pin has been high on two consecutive synchronised samples.
- R8: While the core is running, a low level on the pin asserts `core_rst` three edges later and sets `vec_sel` to 00. Reset is released two synchronised-high samples after the pin rises.
- R9: When both internal sources fire on the same edge, the clock monitor wins and `vec_sel` becomes 10.
- R10: Internal requests that arrive while a reset sequence is running are ignored. They neither change the vector nor lengthen the drive pulse.
- R11: `vec_sel` encodes 00 = power-on/external, 01 = watchdog, 10 = clock monitor, and it never takes the value 11. While `core_rst` is 1 the vector changes only to 00. While the core runs, it is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | E-clock |
| pwr_up | input | 1 | Power-up pulse, asynchronous, active high |
| osc_ok | input | 1 | Oscillator reports active |
| wdog_trip | input | 1 | Watchdog timeout request, one cycle |
| clkmon_trip | input | 1 | Clock-failure request, one cycle |
| rst_pin_in | input | 1 | Sensed level of the shared reset pin |
| rst_pin_oe_low | output | 1 | Enable for the pin driver, which only pulls the pin low |
| core_rst | output | 1 | Core reset, active high |
| vec_sel | output | 2 | Reset vector selection |

## Verification
The bench builds the block with STAB_CYCLES set to 20 and keeps DRIVE_CYCLES = 4 and SAMPLE_DELAY = 2. The short count brings the exact release edge after power-up, and the path where the pin is still held low at the end of the count, within a few dozen cycles. The short count also allows a second power-up in the middle of the run. The unchanged drive and sample lengths let the bench release the pin one edge before and one edge after the sampling point. This separates an internal cause from a slow-rising pin that must be classified as external.

// File: rtl/rst_seq_ctl.sv
module rst_seq_ctl #(
  parameter int STAB_CYCLES  = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int SAMPLE_DELAY = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       pwr_up,
  input  logic       osc_ok,
  input  logic       wdog_trip,
  input  logic       clkmon_trip,
  input  logic       rst_pin_in,
  output logic       rst_pin_oe_low,
  output logic       core_rst,
  output logic [1:0] vec_sel
);

  localparam int WAIT_CYCLES = SAMPLE_DELAY + SYNC_STAGES;
  localparam int MAX_A = (STAB_CYCLES > DRIVE_CYCLES) ? STAB_CYCLES : DRIVE_CYCLES;
  localparam int MAX_CNT = (MAX_A > WAIT_CYCLES) ? MAX_A : WAIT_CYCLES;
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] STAB_LAST  = CNT_W'(STAB_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYCLES - 1);

  localparam logic [1:0] VEC_EXT  = 2'b00;
  localparam logic [1:0] VEC_WDOG = 2'b01;
  localparam logic [1:0] VEC_CMON = 2'b10;

  typedef enum logic [2:0] {
    ST_STAB,
    ST_RUN,
    ST_DRIVE,
    ST_WAIT,
    ST_HOLD
  } st_t;

  st_t                    st;
  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] sync;
  logic                   seen_hi;
  logic                   pin_s;

  assign pin_s          = sync[SYNC_STAGES-1];
  assign rst_pin_oe_low = (st == ST_DRIVE);
  assign core_rst       = (st != ST_RUN);

  always_ff @(posedge clk or posedge pwr_up) begin
    if (pwr_up) begin
      st      <= ST_STAB;
      cnt     <= '0;
      vec_sel <= VEC_EXT;
      seen_hi <= 1'b0;
      sync    <= '1;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], rst_pin_in};
      case (st)
        ST_STAB: begin
          if (osc_ok) begin
            if (cnt == STAB_LAST) begin
              cnt     <= '0;
              seen_hi <= 1'b0;
              st      <= pin_s ? ST_RUN : ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (clkmon_trip || wdog_trip) begin
            st      <= ST_DRIVE;
            cnt     <= '0;
            vec_sel <= clkmon_trip ? VEC_CMON : VEC_WDOG;
          end else if (!pin_s) begin
            st      <= ST_HOLD;
            seen_hi <= 1'b0;
            vec_sel <= VEC_EXT;
          end
        end
        ST_DRIVE: begin
          if (cnt == DRIVE_LAST) begin
            st  <= ST_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == WAIT_LAST) begin
            cnt <= '0;
            if (pin_s) begin
              st <= ST_RUN;
            end else begin
              st      <= ST_HOLD;
              seen_hi <= 1'b0;
              vec_sel <= VEC_EXT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pin_s) begin
            seen_hi <= 1'b1;
            if (seen_hi) st <= ST_RUN;
          end else begin
            seen_hi <= 1'b0;
          end
        end
        default: st <= ST_STAB;
      endcase
    end
  end

endmodule

// File: rtl/rst_seq_ctl_chk.sv
module rst_seq_ctl_chk #(
  parameter int DRIVE_CYCLES = 4
) (
  input logic       clk,
  input logic       pwr_up,
  input logic       core_rst,
  input logic       rst_pin_oe_low,
  input logic [1:0] vec_sel
);

  logic [7:0] drv_run;

  always_ff @(posedge clk or posedge pwr_up) begin
    if (pwr_up)              drv_run <= '0;
    else if (rst_pin_oe_low) drv_run <= (drv_run == 8'hff) ? drv_run : drv_run + 1'b1;
    else                     drv_run <= '0;
  end

  p_drive_in_reset_r5: assert property (@(posedge clk) disable iff (pwr_up)
    rst_pin_oe_low |-> core_rst);

  p_drive_len_r5: assert property (@(posedge clk) disable iff (pwr_up)
    (!rst_pin_oe_low && drv_run != 8'd0) |-> (drv_run == 8'(DRIVE_CYCLES)));

  p_drive_from_run_r10: assert property (@(posedge clk) disable iff (pwr_up)
    $rose(rst_pin_oe_low) |-> !$past(core_rst));

  p_vec_legal_r11: assert property (@(posedge clk) disable iff (pwr_up)
    vec_sel != 2'b11);

  p_vec_in_reset_r11: assert property (@(posedge clk) disable iff (pwr_up)
    (core_rst && $past(core_rst)) |-> ($stable(vec_sel) || vec_sel == 2'b00));

  p_vec_in_run_r11: assert property (@(posedge clk) disable iff (pwr_up)
    (!core_rst && !$past(core_rst)) |-> $stable(vec_sel));

endmodule

bind rst_seq_ctl rst_seq_ctl_chk #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_chk (
  .clk            (clk),
  .pwr_up         (pwr_up),
  .core_rst       (core_rst),
  .rst_pin_oe_low (rst_pin_oe_low),
  .vec_sel        (vec_sel)
);

// File: tb/test_rst_seq_ctl.sv
module test_rst_seq_ctl;
  localparam int STAB = 20;

  logic clk = 1'b0;
  logic pwr_up, osc_ok, wdog_trip, clkmon_trip, ext_low;
  logic rst_pin_oe_low, core_rst;
  logic [1:0] vec_sel;
  logic rst_pin_in;
  int checks = 0;
  int errors = 0;

  assign rst_pin_in = !(rst_pin_oe_low || ext_low);

  always #2 clk = ~clk;

  rst_seq_ctl #(.STAB_CYCLES(STAB)) i_rst_seq_ctl (
    .clk(clk), .pwr_up(pwr_up), .osc_ok(osc_ok), .wdog_trip(wdog_trip),
    .clkmon_trip(clkmon_trip), .rst_pin_in(rst_pin_in),
    .rst_pin_oe_low(rst_pin_oe_low), .core_rst(core_rst), .vec_sel(vec_sel)
  );

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_power_up;
    @(negedge clk);
    pwr_up = 1'b1; osc_ok = 1'b0;
    step(3);
    chk("R1", "core_rst", {1'b0, core_rst}, 2'd1);
    chk("R1", "vec_sel", vec_sel, 2'b00);
    chk("R1", "drive", {1'b0, rst_pin_oe_low}, 2'd0);
    pwr_up = 1'b0;
    step(30);
    chk("R2", "held without osc", {1'b0, core_rst}, 2'd1);
    osc_ok = 1'b1;
    step(STAB - 1);
    chk("R2", "held before count end", {1'b0, core_rst}, 2'd1);
    step(1);
    chk("R2", "released at count end", {1'b0, core_rst}, 2'd0);
    chk("R2", "vec after power-up", vec_sel, 2'b00);
  endtask

  task automatic t_osc_drop;
    osc_ok = 1'b0;
    step(10);
    chk("R4", "osc drop ignored", {1'b0, core_rst}, 2'd0);
    osc_ok = 1'b1;
    step(2);
  endtask

  task automatic t_internal(string req, bit wd, bit cm, bit late, logic [1:0] exp_vec);
    wdog_trip = wd; clkmon_trip = cm;
    step(1);
    wdog_trip = 1'b0; clkmon_trip = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R5", "drive on", {1'b0, rst_pin_oe_low}, 2'd1);
      chk("R5", "core in reset", {1'b0, core_rst}, 2'd1);
      if (late && k == 1) begin wdog_trip = 1'b1; clkmon_trip = 1'b1; end
      if (late && k == 2) begin wdog_trip = 1'b0; clkmon_trip = 1'b0; end
      step(1);
    end
    chk("R5", "drive off after length", {1'b0, rst_pin_oe_low}, 2'd0);
    for (int k = 0; k < 4; k++) begin
      chk("R6", "held during sample wait", {1'b0, core_rst}, 2'd1);
      step(1);
    end
    chk("R6", "released internal", {1'b0, core_rst}, 2'd0);
    chk(req, "vector", vec_sel, exp_vec);
    step(3);
  endtask

  task automatic t_pin_stretch(int rel, bit exp_ext);
    wdog_trip = 1'b1; ext_low = 1'b1;
    step(1);
    wdog_trip = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == rel) ext_low = 1'b0;
      step(1);
    end
    if (exp_ext) begin
      chk("R7", "slow pin held", {1'b0, core_rst}, 2'd1);
      chk("R7", "slow pin vec", vec_sel, 2'b00);
      step(1);
      chk("R7", "one high sample", {1'b0, core_rst}, 2'd1);
      step(1);
      chk("R7", "released after two highs", {1'b0, core_rst}, 2'd0);
      chk("R7", "vec stays ext", vec_sel, 2'b00);
    end else begin
      chk("R6", "pin high in time", {1'b0, core_rst}, 2'd0);
      chk("R6", "vec wdog", vec_sel, 2'b01);
    end
    step(3);
  endtask

  task automatic t_ext_run;
    ext_low = 1'b1;
    step(2);
    chk("R8", "not yet in reset", {1'b0, core_rst}, 2'd0);
    step(1);
    chk("R8", "ext reset asserted", {1'b0, core_rst}, 2'd1);
    chk("R8", "ext vec", vec_sel, 2'b00);
    step(5);
    chk("R8", "held while pin low", {1'b0, core_rst}, 2'd1);
    ext_low = 1'b0;
    step(3);
    chk("R8", "held one high sample", {1'b0, core_rst}, 2'd1);
    step(1);
    chk("R8", "released", {1'b0, core_rst}, 2'd0);
    step(2);
  endtask

  task automatic t_stab_pin_low;
    pwr_up = 1'b1;
    step(2);
    chk("R1", "vec cleared by power-up", vec_sel, 2'b00);
    chk("R1", "core_rst on power-up", {1'b0, core_rst}, 2'd1);
    ext_low = 1'b1; osc_ok = 1'b1;
    step(1);
    pwr_up = 1'b0;
    step(STAB);
    chk("R3", "held at count end", {1'b0, core_rst}, 2'd1);
    step(8);
    chk("R3", "still held", {1'b0, core_rst}, 2'd1);
    ext_low = 1'b0;
    step(3);
    chk("R3", "one high sample", {1'b0, core_rst}, 2'd1);
    step(1);
    chk("R3", "released", {1'b0, core_rst}, 2'd0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    pwr_up = 1'b1; osc_ok = 1'b0; wdog_trip = 1'b0; clkmon_trip = 1'b0; ext_low = 1'b0;
    t_power_up();
    t_osc_drop();
    t_internal("R11", 1'b1, 1'b0, 1'b0, 2'b01);
    t_internal("R11", 1'b0, 1'b1, 1'b0, 2'b10);
    t_internal("R9", 1'b1, 1'b1, 1'b0, 2'b10);
    t_internal("R10", 1'b1, 1'b0, 1'b1, 2'b01);
    t_pin_stretch(5, 1'b0);
    t_pin_stretch(6, 1'b1);
    t_internal("R11", 1'b1, 1'b0, 1'b0, 2'b01);
    t_ext_run();
    t_internal("R11", 1'b0, 1'b1, 1'b0, 2'b10);
    t_stab_pin_low();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule